// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Access Sequencer

This block performs one programmed-I/O access at a time on a parallel ATA bus. A requester presents a 4-bit register address, a direction bit and a 16-bit write word. Once the block is idle and enabled it takes the request and drives the bus through four counted phases. The first phase is address and chip-select setup. The second holds the strobe low. The third holds the written word after the strobe rises. The fourth is a recovery gap. A read returns the word captured from the data bus together with a single-cycle completion pulse. A write raises the same pulse.

The phase lengths come from three timing sets that are programmed independently. A compatible set covers every register access. Two fast sets, one for each attached device, apply to data-port transfers when the device's fast enable is set. The device is chosen from a shadow of the select bit that was last written to the drive/head register. Each timing set can also let the device's ready line hold the strobe low longer. That line passes through a two-stage synchronizer before it is used. A separate control drives the active-low bus reset line.

Top module: `ata_pio_engine`

## Requirements
- R1: While an access is active (setup, strobe and hold phases), address bit 3 picks the chip select: 1 drives `cs1_n` low, 0 drives `cs0_n` low, and exactly one is low. `da` equals address bits 2..0. Both chip selects are high in recovery and idle.
- R2: Each timing word packs four 8-bit counts: bits 7..0 setup, 15..8 strobe, 23..16 hold, 31..24 recovery. Each phase lasts max(count,1) clocks, in that order. `done` goes high in the clock that follows the last recovery clock.
- R3: A read drives `dior_n` low only during the strobe phase and keeps `diow_n` high. `rdata` takes `dd_in` as sampled in the last strobe clock and holds it while `done` is high.
- R4: A write drives `diow_n` low only during the strobe phase and keeps `dior_n` high. `dd_oe` is high from the first setup clock through the last hold clock, with `dd_out` equal to the write word. At every other time `dd_oe` is low, and it is never high for a read.
- R5: An access to address 0 (the data port) uses fast set 0 or fast set 1 for the currently selected device when that set's fast enable is high. Every other access, and every data-port access whose device fast enable is low, uses the compatible set.
- R6: The selected device is bit 4 of the write word of the most recent write to address 6 (the drive/head register). It becomes 0 on reset and takes effect for accesses accepted after that write.
- R7: When the active set's ready enable is high, each strobe clock in which the synchronized `iordy` is low adds one clock to the strobe phase. If `iordy` is low at strobe start and rises during strobe clock J, the strobe lasts J+1+max(count,1) clocks. When the ready enable is low, `iordy` has no effect.
- R8: `busy` is high from the clock after acceptance until `done`. A request offered while `busy` is high is ignored: bus lines keep the current access, and no further access follows.
- R9: While `cfg_enable` is low, requests are ignored: no chip select, strobe, `busy` or `done` activity.
- R10: `ata_rst_n` is the inverse of `cfg_bus_reset`, delayed by one clock. It is low while `rst` is high.
- R11: `done` is a single-clock pulse, issued once per accepted access.
- R12: After reset both chip selects and both strobes are high. `dd_oe`, `busy` and `done` are low and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows new accesses to start |
| cfg_bus_reset | input | 1 | Asserts the bus reset line |
| cmp_timing | input | 32 | Compatible set counts {recovery, hold, strobe, setup} |
| cmp_rdy_en | input | 1 | Ready stretching for the compatible set |
| fast0_timing | input | 32 | Device 0 fast set counts |
| fast0_rdy_en | input | 1 | Ready stretching for fast set 0 |
| fast0_en | input | 1 | Use fast set 0 for device 0 data-port accesses |
| fast1_timing | input | 32 | Device 1 fast set counts |
| fast1_rdy_en | input | 1 | Ready stretching for fast set 1 |
| fast1_en | input | 1 | Use fast set 1 for device 1 data-port accesses |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 4 | Bit 3 chip-select choice, bits 2..0 device address |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write word |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Last word read |
| ata_rst_n | output | 1 | Active-low bus reset |
| dd_in | input | 16 | Data bus from pads |
| dd_out | output | 16 | Data bus to pads |
| dd_oe | output | 1 | Data bus output enable |
| da | output | 3 | Device address lines |
| cs0_n | output | 1 | Command block chip select, active low |
| cs1_n | output | 1 | Control block chip select, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| iordy | input | 1 | Device ready, asynchronous |

## Verification
Several properties are checked on every clock. The two strobes are never low together. A strobe always has one chip select under it. The output enable never appears on a read. The counter only counts down within a phase and freezes while the synchronized ready is low. The captured request stays frozen while busy. The device shadow changes only after a drive/head write. `done` never lasts two clocks. The bus reset follows its control one clock late. The bench alone shows the exact length of each phase under each timing set, the choice of set by address, fast enables and shadowed device, and how far the strobe stretches after `iordy` rises. It also shows the captured read word and that requests are ignored while busy or disabled.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int TIM_W       = 8;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 4;
    localparam int DA_W        = 3;
    localparam int N_DEV       = 2;
    localparam int DEV_W       = $clog2(N_DEV);
    localparam int SYNC_STAGES = 2;
    localparam int N_PHASE_CNT = 4;
    localparam int TWORD_W     = N_PHASE_CNT * TIM_W;

    // Address decoding the sequencer depends on
    localparam logic [ADDR_W-1:0] DATA_PORT_ADDR = 4'h0;
    localparam logic [ADDR_W-1:0] DEVHEAD_ADDR   = 4'h6;
    localparam int                DEV_BIT        = 4;
    localparam int                CS_SEL_BIT     = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic             rdy_en;
        logic [TIM_W-1:0] recov;
        logic [TIM_W-1:0] hold;
        logic [TIM_W-1:0] strobe;
        logic [TIM_W-1:0] setup;
    } timing_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } access_t;

    function automatic timing_t unpack_timing(input logic [TWORD_W-1:0] w,
                                              input logic rdy);
        timing_t t;
        t.setup  = w[0*TIM_W +: TIM_W];
        t.strobe = w[1*TIM_W +: TIM_W];
        t.hold   = w[2*TIM_W +: TIM_W];
        t.recov  = w[3*TIM_W +: TIM_W];
        t.rdy_en = rdy;
        return t;
    endfunction

    // A phase ends when its counter has reached one (or was loaded with zero)
    function automatic logic last_tick(input logic [TIM_W-1:0] c);
        return (c <= TIM_W'(1));
    endfunction

    function automatic logic bus_active(input phase_e p);
        return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/ata_pio_rdysync.sv
module ata_pio_rdysync #(
    parameter int STAGES = ata_pio_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ata_pio_tsel.sv
module ata_pio_tsel
    import ata_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  access_t          req,
    input  timing_t          cmp_set,
    input  timing_t          fast_set [N_DEV],
    input  logic [N_DEV-1:0] fast_en,
    output timing_t          chosen,
    output logic [DEV_W-1:0] dev_sel
);

    logic is_data_port;
    logic shadow_wr;

    assign is_data_port = (req.addr == DATA_PORT_ADDR);
    assign shadow_wr    = take && req.write && (req.addr == DEVHEAD_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_sel <= '0;
        end else if (shadow_wr) begin
            dev_sel <= req.wdata[DEV_BIT +: DEV_W];
        end
    end

    always_comb begin
        chosen = cmp_set;
        if (is_data_port && fast_en[dev_sel]) begin
            chosen = fast_set[dev_sel];
        end
    end

    // R6
    dev_update_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_sel != $past(dev_sel)) |-> $past(take && req.write && (req.addr == DEVHEAD_ADDR)));

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  access_t           req,
    input  timing_t           tim,
    input  logic              rdy_sync,
    input  logic [DATA_W-1:0] dd_in,
    output phase_e            phase,
    output access_t           cur,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    timing_t          tim_q;
    logic [TIM_W-1:0] cnt;
    logic             tick_ok;
    logic             at_end;

    // The strobe phase only counts once the device reports ready
    assign tick_ok = (phase != PH_STROBE) || !tim_q.rdy_en || rdy_sync;
    assign at_end  = last_tick(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tim_q <= '0;
            cur   <= '0;
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (take) begin
                        cur   <= req;
                        tim_q <= tim;
                        cnt   <= tim.setup;
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (at_end) begin
                        phase <= PH_STROBE;
                        cnt   <= tim_q.strobe;
                    end else begin
                        cnt <= cnt - TIM_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (tick_ok) begin
                        if (at_end) begin
                            phase <= PH_HOLD;
                            cnt   <= tim_q.hold;
                            if (!cur.write) begin
                                rdata <= dd_in;
                            end
                        end else begin
                            cnt <= cnt - TIM_W'(1);
                        end
                    end
                end
                PH_HOLD: begin
                    if (at_end) begin
                        phase <= PH_RECOV;
                        cnt   <= tim_q.recov;
                    end else begin
                        cnt <= cnt - TIM_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (at_end) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - TIM_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    ready_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && tim_q.rdy_en && !rdy_sync) |=> (phase == PH_STROBE && $stable(cnt)));

    // R8
    acc_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase != PH_IDLE)) |-> $stable(cur));

    // R2
    cnt_down_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && phase == $past(phase)) |-> (cnt <= $past(cnt)));

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
    import ata_pio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_enable,
    input  logic               cfg_bus_reset,
    input  logic [TWORD_W-1:0] cmp_timing,
    input  logic               cmp_rdy_en,
    input  logic [TWORD_W-1:0] fast0_timing,
    input  logic               fast0_rdy_en,
    input  logic               fast0_en,
    input  logic [TWORD_W-1:0] fast1_timing,
    input  logic               fast1_rdy_en,
    input  logic               fast1_en,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic               ata_rst_n,
    input  logic [DATA_W-1:0]  dd_in,
    output logic [DATA_W-1:0]  dd_out,
    output logic               dd_oe,
    output logic [DA_W-1:0]    da,
    output logic               cs0_n,
    output logic               cs1_n,
    output logic               dior_n,
    output logic               diow_n,
    input  logic               iordy
);

    access_t          req;
    access_t          cur;
    timing_t          cmp_set;
    timing_t          fast_set [N_DEV];
    timing_t          chosen;
    logic [N_DEV-1:0] fast_en;
    logic [DEV_W-1:0] dev_sel;
    logic             rdy_sync;
    logic             take;
    logic             active;
    phase_e           phase;

    assign req     = '{addr: req_addr, write: req_write, wdata: req_wdata};
    assign cmp_set = unpack_timing(cmp_timing, cmp_rdy_en);
    assign fast_set[0] = unpack_timing(fast0_timing, fast0_rdy_en);
    assign fast_set[1] = unpack_timing(fast1_timing, fast1_rdy_en);
    assign fast_en = {fast1_en, fast0_en};

    assign take = req_valid && cfg_enable && (phase == PH_IDLE);

    ata_pio_rdysync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (iordy),
        .sync_out (rdy_sync)
    );

    ata_pio_tsel u_tsel (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .req      (req),
        .cmp_set  (cmp_set),
        .fast_set (fast_set),
        .fast_en  (fast_en),
        .chosen   (chosen),
        .dev_sel  (dev_sel)
    );

    ata_pio_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .req      (req),
        .tim      (chosen),
        .rdy_sync (rdy_sync),
        .dd_in    (dd_in),
        .phase    (phase),
        .cur      (cur),
        .rdata    (rdata),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ata_rst_n <= 1'b0;
        end else begin
            ata_rst_n <= !cfg_bus_reset;
        end
    end

    // Bus lines decode from the registered phase and the captured request
    always_comb begin
        active = bus_active(phase);
        busy   = (phase != PH_IDLE);
        cs0_n  = !(active && !cur.addr[CS_SEL_BIT]);
        cs1_n  = !(active &&  cur.addr[CS_SEL_BIT]);
        da     = active ? cur.addr[DA_W-1:0] : '0;
        dior_n = !((phase == PH_STROBE) && !cur.write);
        diow_n = !((phase == PH_STROBE) &&  cur.write);
        dd_oe  = active && cur.write;
        dd_out = cur.wdata;
    end

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    // R4
    oe_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> dior_n);

    // R1
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> (cs0_n != cs1_n));

    // R10
    bus_rst_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ata_rst_n == !$past(cfg_bus_reset)));

endmodule

// File: tb/sim_ata_pio_engine.sv
module sim_ata_pio_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_enable, cfg_bus_reset;
    logic [31:0] cmp_timing, fast0_timing, fast1_timing;
    logic        cmp_rdy_en, fast0_rdy_en, fast0_en, fast1_rdy_en, fast1_en;
    logic        req_valid, req_write;
    logic [3:0]  req_addr;
    logic [15:0] req_wdata;
    logic        busy, done, ata_rst_n, dd_oe, cs0_n, cs1_n, dior_n, diow_n, iordy;
    logic [15:0] rdata, dd_in, dd_out;
    logic [2:0]  da;

    int checks = 0;
    int errors = 0;
    int ct[4], f0[4], f1[4];
    bit crdy, f0rdy, f1rdy, f0en, f1en;
    bit mdev;

    always #10 clk = ~clk;

    ata_pio_engine u0 (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_bus_reset(cfg_bus_reset),
        .cmp_timing(cmp_timing), .cmp_rdy_en(cmp_rdy_en),
        .fast0_timing(fast0_timing), .fast0_rdy_en(fast0_rdy_en), .fast0_en(fast0_en),
        .fast1_timing(fast1_timing), .fast1_rdy_en(fast1_rdy_en), .fast1_en(fast1_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .ata_rst_n(ata_rst_n),
        .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe), .da(da),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .dior_n(dior_n), .diow_n(diow_n), .iordy(iordy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int mx(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // 0 compatible, 1 fast set 0, 2 fast set 1 (R5, R6 model)
    function automatic int kind_of(input logic [3:0] a);
        if (a == 4'h0 && (mdev ? f1en : f0en)) return mdev ? 2 : 1;
        return 0;
    endfunction

    function automatic int fld(input int k, input int i);
        if (k == 1) return f0[i];
        if (k == 2) return f1[i];
        return ct[i];
    endfunction

    function automatic bit rdy_of(input int k);
        if (k == 1) return f0rdy;
        if (k == 2) return f1rdy;
        return crdy;
    endfunction

    task automatic apply_timing();
        cmp_timing   = {8'(ct[3]), 8'(ct[2]), 8'(ct[1]), 8'(ct[0])};
        fast0_timing = {8'(f0[3]), 8'(f0[2]), 8'(f0[1]), 8'(f0[0])};
        fast1_timing = {8'(f1[3]), 8'(f1[2]), 8'(f1[1]), 8'(f1[0])};
        cmp_rdy_en = crdy; fast0_rdy_en = f0rdy; fast1_rdy_en = f1rdy;
        fast0_en = f0en; fast1_en = f1en;
    endtask

    task automatic set_all(ref int s[4], input int a, input int b, input int c, input int d);
        s[0] = a; s[1] = b; s[2] = c; s[3] = d;
    endtask

    task automatic run_access(input logic [3:0] a, input bit w, input logic [15:0] wd,
                              input logic [15:0] rv, input int stall, input bit poke);
        int k, e1, e2, e4, ee;
        int obs, npre, nstb, npost, nrec, pk;
        bit bad_bus, bad_oe, bad_busy, got, csact, stb;
        apply_timing();
        k  = kind_of(a);
        e1 = mx(fld(k, 0));
        e2 = (rdy_of(k) && stall > 0) ? stall + 1 + mx(fld(k, 1)) : mx(fld(k, 1));
        e4 = mx(fld(k, 2));
        ee = mx(fld(k, 3));
        @(negedge clk);
        dd_in = rv;
        if (stall > 0) iordy = 1'b0;
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (w && a == 4'h6) mdev = wd[4];
        obs = 0; npre = 0; nstb = 0; npost = 0; nrec = 0; pk = 0;
        bad_bus = 0; bad_oe = 0; bad_busy = 0; got = 0;
        for (int n = 0; n < 3000; n++) begin
            if (done) begin got = 1; break; end
            csact = !cs0_n || !cs1_n;
            stb   = !dior_n || !diow_n;
            if (!busy) bad_busy = 1;
            if (csact) begin
                if (cs0_n == cs1_n) bad_bus = 1;
                if ((!cs1_n) != a[3]) bad_bus = 1;
                if (da != a[2:0]) bad_bus = 1;
                if (dd_oe != w) bad_oe = 1;
                if (w && dd_out != wd) bad_oe = 1;
            end else if (dd_oe) bad_oe = 1;
            if (stb) begin
                if (w ? (diow_n || !dior_n) : (dior_n || !diow_n)) bad_bus = 1;
                if (!csact) bad_bus = 1;
            end
            case (obs)
                0: if (stb) begin obs = 1; nstb++; end else if (csact) npre++; else bad_bus = 1;
                1: if (stb) nstb++;
                   else if (csact) begin obs = 2; npost++; end
                   else begin obs = 3; nrec++; end
                2: if (stb) bad_bus = 1;
                   else if (csact) npost++;
                   else begin obs = 3; nrec++; end
                default: begin nrec++; if (csact) bad_bus = 1; end
            endcase
            if (stall > 0 && obs == 1 && nstb == stall) iordy = 1'b1;
            if (poke && pk == 0 && stb) begin
                req_valid = 1'b1; req_addr = ~a; req_write = ~w; req_wdata = ~wd; pk = 1;
            end else if (pk == 1) begin
                req_valid = 1'b0; pk = 2;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(got, "R11 done pulse seen", got, 1);
        chk(npre == e1, "R2 setup length", npre, e1);
        chk(nstb == e2, (stall > 0) ? "R7 strobe length with ready" : "R2 strobe length", nstb, e2);
        chk(npost == e4, "R2 hold length", npost, e4);
        chk(nrec == ee, "R2 recovery length", nrec, ee);
        chk(!bad_bus, "R1 R3 R4 chip select, address and strobe lines", bad_bus, 0);
        chk(!bad_oe, "R4 output enable and write data", bad_oe, 0);
        chk(!bad_busy, "R8 busy during access", bad_busy, 0);
        chk(!busy, "R8 busy clear at done", busy, 0);
        if (!w) chk(rdata == rv, "R3 captured read word", rdata, rv);
        @(negedge clk);
        chk(!done, "R11 done single cycle", done, 0);
        iordy = 1'b1;
        if (poke) begin
            bad_bus = 0;
            for (int n = 0; n < 5; n++) begin
                if (!cs0_n || !cs1_n || busy || done) bad_bus = 1;
                @(negedge clk);
            end
            chk(!bad_bus, "R8 request while busy ignored", bad_bus, 0);
        end
    endtask

    initial begin
        int sd;
        bit bad;
        logic [3:0] ra;
        sd = $urandom(32'd1357);
        rst = 1'b1; cfg_enable = 1'b0; cfg_bus_reset = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
        dd_in = '0; iordy = 1'b1; mdev = 1'b0;
        set_all(ct, 6, 28, 2, 23); set_all(f0, 6, 28, 2, 23); set_all(f1, 6, 28, 2, 23);
        crdy = 0; f0rdy = 0; f1rdy = 0; f0en = 0; f1en = 0;
        apply_timing();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(cs0_n && cs1_n, "R12 chip selects high in reset", {cs0_n, cs1_n}, 3);
        chk(dior_n && diow_n, "R12 strobes high in reset", {dior_n, diow_n}, 3);
        chk(!dd_oe && !busy && !done, "R12 oe busy done low", {dd_oe, busy, done}, 0);
        chk(rdata == 16'h0, "R12 rdata zero", rdata, 0);
        chk(!ata_rst_n, "R10 bus reset low during reset", ata_rst_n, 0);
        rst = 1'b0; cfg_enable = 1'b1;
        repeat (3) @(negedge clk);

        // Default timings, compatible register read
        run_access(4'h7, 0, 16'h0, 16'hA55A, 0, 0);
        run_access(4'hE, 1, 16'h1234, 16'h0, 0, 0);

        // R5 / R6 / R12: timing set choice through the device shadow
        set_all(f0, 2, 3, 1, 4); set_all(f1, 5, 1, 3, 2); set_all(ct, 3, 6, 2, 5);
        f0en = 1; f1en = 1;
        run_access(4'h0, 0, 16'h0, 16'hBEEF, 0, 0);   // device 0 after reset
        run_access(4'h6, 1, 16'h0010, 16'h0, 0, 0);   // select device 1
        run_access(4'h0, 0, 16'h0, 16'h0F0F, 0, 0);
        run_access(4'h0, 1, 16'hCAFE, 16'h0, 0, 0);
        f1en = 0;
        run_access(4'h0, 0, 16'h0, 16'h7777, 0, 0);   // R5 fast disabled
        run_access(4'h6, 1, 16'h00EF, 16'h0, 0, 0);   // back to device 0
        run_access(4'h0, 0, 16'h0, 16'h3C3C, 0, 0);
        run_access(4'h8, 0, 16'h0, 16'h1111, 0, 0);   // control block, compatible

        // R7 ready stretching and its bypass
        crdy = 1; ct[1] = 5;
        run_access(4'h7, 0, 16'h0, 16'h2222, 3, 0);
        run_access(4'h1, 1, 16'h4321, 16'h0, 1, 0);
        crdy = 0;
        run_access(4'h7, 0, 16'h0, 16'h3333, 3, 0);

        // R2 zero counts give one clock per phase
        set_all(ct, 0, 0, 0, 0);
        run_access(4'h2, 0, 16'h0, 16'h4444, 0, 0);
        run_access(4'h3, 1, 16'h8001, 16'h0, 0, 0);

        // R8 request while busy
        set_all(ct, 2, 4, 2, 3);
        run_access(4'h5, 0, 16'h0, 16'h5555, 0, 1);
        run_access(4'hA, 1, 16'h6789, 16'h0, 0, 1);

        // R9 disabled
        cfg_enable = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 4'h9; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bad = 0;
        for (int n = 0; n < 10; n++) begin
            if (!cs0_n || !cs1_n || !dior_n || !diow_n || busy || done) bad = 1;
            @(negedge clk);
        end
        chk(!bad, "R9 request ignored while disabled", bad, 0);
        cfg_enable = 1'b1;

        // R10 bus reset control
        cfg_bus_reset = 1'b1;
        @(negedge clk);
        chk(!ata_rst_n, "R10 bus reset asserted", ata_rst_n, 0);
        cfg_bus_reset = 1'b0;
        @(negedge clk);
        chk(ata_rst_n, "R10 bus reset released", ata_rst_n, 1);

        // Random mix
        for (int it = 0; it < 80; it++) begin
            for (int i = 0; i < 4; i++) begin
                ct[i] = $urandom_range(0, 9); f0[i] = $urandom_range(0, 9); f1[i] = $urandom_range(0, 9);
            end
            crdy = 1'($urandom_range(0, 1)); f0rdy = 1'($urandom_range(0, 1));
            f1rdy = 1'($urandom_range(0, 1));
            f0en = 1'($urandom_range(0, 1)); f1en = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0, 1: ra = 4'h0;
                2: ra = 4'h6;
                default: ra = 4'($urandom_range(0, 15));
            endcase
            run_access(ra, 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
                       $urandom_range(0, 3), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule